// File: doc/BRIEF.md
# PCI Interrupt Pin Router Configuration

This block is the configuration register file of a PCI-to-ISA bridge function. Its main job is to steer the four level-sensitive PCI interrupt pins (INTA, INTB, INTC, INTD) onto ISA interrupt request numbers. Software programs one routing byte per pin through configuration writes. The block then presents, for each pin, a 4-bit IRQ number and an enable. It also drives a request vector: each line of that vector is the OR of the pin requests that are routed to it.

The header portion answers identity reads with fixed values. Writes to the read-only header locations are filtered out. The command and status bytes are forced into their allowed patterns when written. Only function 0 is implemented. Any access to another function number leaves the block untouched and reads as all ones. Reads are combinational from the current address. Writes take effect at the clock edge where `cfg_wr` is sampled high, and the routing outputs reflect them from that edge on.

Top module: `pirq_router`

## Requirements
- R1: After reset, all four routing bytes read 0x80, `route_en` is 0 and `irq_req` stays 0 whatever `pin_req` is.
- R2: With function 0, reads return these values: vendor bytes 0x00/0x01 = 0x39/0x10, device bytes 0x02/0x03 = 0x08/0x00, 0x08 = 0x00, class bytes 0x09/0x0A/0x0B = 0x00/0x01/0x06, header byte 0x0E = 0x00. At reset, command 0x04 = 0x07, 0x05 = 0x00, status 0x06 = 0x80 and 0x07 = 0x02.
- R3: Routing byte 0x41 drives pin INTA (pin index 0), 0x42 drives INTC (index 2), 0x43 drives INTB (index 1) and 0x44 drives INTD (index 3). Pin p uses `route_irq[4p+3:4p]` and `route_en[p]`, and `pin_req[p]` is that pin's request.
- R4: A write to address 0x00–0x03, 0x08–0x0B, 0x0E, or any address from 0x0F to 0x40 changes nothing that can be read back.
- R5: A write to 0x04 stores (data AND 0x08) OR 0x07. A write to 0x06 stores 0x00. After any write, 0x05 reads 0x00 and 0x07 reads 0x02.
- R6: In a routing byte, bit 7 set clears that pin's `route_en`, and the pin then adds nothing to `irq_req`. With bit 7 clear, bits 3:0 are the IRQ number. A routing byte reads back exactly as written.
- R7: When `cfg_func` is nonzero, a write changes no state and `cfg_rdata` is 0xFF.
- R8: `irq_req[n]` is high exactly when some enabled pin routed to n has its request high. Two pins routed to the same number are ORed onto that line.
- R9: IRQ numbers 0 and 2 are routed like any other number, with no remapping.
- R10: A routing write shows on `route_irq`, `route_en` and `irq_req` from the clock edge that accepts it.
- R11: Bytes 0x0C and 0x0D are plain read/write storage. Addresses above 0x44 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_func | input | 3 | Function number of the configuration access |
| cfg_addr | input | 8 | Register byte address |
| cfg_wr | input | 1 | Write strobe, sampled at the rising edge |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the current address and function |
| pin_req | input | 4 | Active-high requests of INTA, INTB, INTC, INTD (bit 0 = INTA) |
| route_irq | output | 16 | Per-pin IRQ number, 4 bits per pin, indexed by pin |
| route_en | output | 4 | Per-pin routing enable, indexed by pin |
| irq_req | output | 16 | Routed request vector, one bit per IRQ number |

## Verification
Most wrong internal states in this block show up directly at the ports. A corrupted routing slot appears on `route_irq` or `route_en` at the edge that wrote it. It also appears as a readback mismatch, with no delay, since reads are combinational. A mistake in slot-to-pin ordering only shows when the pins are programmed to distinct numbers and then requested one at a time. For that reason the bench drives each pin alone against a distinct route. A filtering or masking error stays hidden until the affected byte is read back, so every discarded or masked write is followed at once by a read of the same address.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int PIN_COUNT = 4;
    localparam int SLOT_W    = $clog2(PIN_COUNT);
    localparam int IRQ_NUM_W = 4;
    localparam logic [7:0] ROUTE_BASE = 8'h41;
    localparam logic [7:0] ROUTE_RESET = 8'h80;

    typedef struct packed {
        logic [7:0]                command;
        logic [7:0]                status;
        logic [7:0]                line_size;
        logic [7:0]                latency;
        logic [PIN_COUNT-1:0][7:0] slot;
    } cfg_state_t;

    // Slot k (address ROUTE_BASE+k) feeds pin index with the two index bits swapped
    function automatic int slot_to_pin(input int s);
        return ((s & 1) << 1) | ((s >> 1) & 1);
    endfunction

    function automatic logic addr_locked(input logic [7:0] a);
        logic lk;
        lk = 1'b0;
        if (a <= 8'h03) lk = 1'b1;
        if (a >= 8'h08 && a <= 8'h0B) lk = 1'b1;
        if (a >= 8'h0E && a <= 8'h40) lk = 1'b1;
        return lk;
    endfunction

endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
    import pirq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                cfg_func,
    input  logic [7:0]                cfg_addr,
    input  logic                      cfg_wr,
    input  logic [7:0]                cfg_wdata,
    output logic [7:0]                cfg_rdata,
    output logic [PIN_COUNT-1:0][7:0] pin_route
);

    cfg_state_t st_d, st_q;

    logic             in_window;
    logic [SLOT_W-1:0] slot_idx;
    logic             wr_ok;

    assign in_window = (cfg_addr >= ROUTE_BASE) && (cfg_addr < ROUTE_BASE + 8'(PIN_COUNT));
    assign slot_idx  = SLOT_W'(cfg_addr - ROUTE_BASE);
    assign wr_ok     = cfg_wr && (cfg_func == 3'd0) && !addr_locked(cfg_addr);

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            case (cfg_addr)
                8'h04:   st_d.command   = (cfg_wdata & 8'h08) | 8'h07;
                8'h06:   st_d.status    = 8'h00;
                8'h0C:   st_d.line_size = cfg_wdata;
                8'h0D:   st_d.latency   = cfg_wdata;
                default: if (in_window) st_d.slot[slot_idx] = cfg_wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.command   <= 8'h07;
            st_q.status    <= 8'h80;
            st_q.line_size <= 8'h00;
            st_q.latency   <= 8'h00;
            st_q.slot      <= {PIN_COUNT{ROUTE_RESET}};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = 8'h00;
        if (cfg_func != 3'd0) begin
            cfg_rdata = 8'hFF;
        end else begin
            case (cfg_addr)
                8'h00:   cfg_rdata = 8'h39;
                8'h01:   cfg_rdata = 8'h10;
                8'h02:   cfg_rdata = 8'h08;
                8'h03:   cfg_rdata = 8'h00;
                8'h04:   cfg_rdata = st_q.command;
                8'h06:   cfg_rdata = st_q.status;
                8'h07:   cfg_rdata = 8'h02;
                8'h0A:   cfg_rdata = 8'h01;
                8'h0B:   cfg_rdata = 8'h06;
                8'h0C:   cfg_rdata = st_q.line_size;
                8'h0D:   cfg_rdata = st_q.latency;
                default: if (in_window) cfg_rdata = st_q.slot[slot_idx];
            endcase
        end
    end

    for (genvar s = 0; s < PIN_COUNT; s++) begin : g_pin_order
        assign pin_route[slot_to_pin(s)] = st_q.slot[s];
    end

    AST_FUNC_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_func != 3'd0) |=> $stable(st_q)); // R7
    AST_FUNC_RD_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_func != 3'd0) |-> (cfg_rdata == 8'hFF)); // R7
    AST_LOCKED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && addr_locked(cfg_addr)) |=> $stable(st_q)); // R4
    AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_func == 3'd0 && cfg_addr == 8'h06) |=> (st_q.status == 8'h00)); // R5

endmodule

// File: rtl/pirq_irq_map.sv
module pirq_irq_map
    import pirq_pkg::*;
#(
    parameter int IRQ_LINES = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [PIN_COUNT*IRQ_NUM_W-1:0]  route_irq,
    input  logic [PIN_COUNT-1:0]            route_en,
    input  logic [PIN_COUNT-1:0]            pin_req,
    output logic [IRQ_LINES-1:0]            irq_req
);

    always_comb begin
        irq_req = '0;
        for (int n = 0; n < IRQ_LINES; n++) begin
            for (int p = 0; p < PIN_COUNT; p++) begin
                if (route_en[p] && pin_req[p] &&
                    (int'(route_irq[p*IRQ_NUM_W +: IRQ_NUM_W]) == n))
                    irq_req[n] = 1'b1;
            end
        end
    end

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_chk
        AST_ROUTED_REQ_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
            (route_en[p] && pin_req[p] &&
             int'(route_irq[p*IRQ_NUM_W +: IRQ_NUM_W]) < IRQ_LINES)
            |-> irq_req[route_irq[p*IRQ_NUM_W +: IRQ_NUM_W]]); // R8
    end

    AST_NO_SPURIOUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> (|(pin_req & route_en))); // R6

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int IRQ_LINES = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [2:0]                     cfg_func,
    input  logic [7:0]                     cfg_addr,
    input  logic                           cfg_wr,
    input  logic [7:0]                     cfg_wdata,
    output logic [7:0]                     cfg_rdata,
    input  logic [PIN_COUNT-1:0]           pin_req,
    output logic [PIN_COUNT*IRQ_NUM_W-1:0] route_irq,
    output logic [PIN_COUNT-1:0]           route_en,
    output logic [IRQ_LINES-1:0]           irq_req
);

    logic [PIN_COUNT-1:0][7:0] pin_route;

    pirq_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_func  (cfg_func),
        .cfg_addr  (cfg_addr),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .pin_route (pin_route)
    );

    for (genvar p = 0; p < PIN_COUNT; p++) begin : g_route
        assign route_irq[p*IRQ_NUM_W +: IRQ_NUM_W] = pin_route[p][IRQ_NUM_W-1:0];
        assign route_en[p] = ~pin_route[p][7];
    end

    pirq_irq_map #(.IRQ_LINES(IRQ_LINES)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .route_irq (route_irq),
        .route_en  (route_en),
        .pin_req   (pin_req),
        .irq_req   (irq_req)
    );

endmodule

// File: tb/test_pirq_router.sv
module test_pirq_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_func = '0;
    logic [7:0]  cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [3:0]  pin_req = '0;
    logic [15:0] route_irq;
    logic [3:0]  route_en;
    logic [15:0] irq_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pirq_router i_pirq_router (
        .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pin_req(pin_req), .route_irq(route_irq), .route_en(route_en), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_func = '0;
    endtask

    task automatic read_chk(input string req, input logic [2:0] f, input logic [7:0] a,
                            input logic [7:0] exp);
        cfg_func = f; cfg_addr = a; cfg_wr = 1'b0;
        #1;
        check(req, {24'h0, cfg_rdata}, {24'h0, exp});
        cfg_func = '0;
    endtask

    task automatic t_reset;
        pin_req = 4'hF;
        #1;
        check("R1 route_en", {28'h0, route_en}, 32'h0);
        check("R1 irq_req", {16'h0, irq_req}, 32'h0);
        for (int k = 0; k < 4; k++) read_chk("R1 route byte", 3'd0, 8'h41 + 8'(k), 8'h80);
        pin_req = 4'h0;
    endtask

    task automatic t_identity;
        read_chk("R2 vendor lo", 3'd0, 8'h00, 8'h39);
        read_chk("R2 vendor hi", 3'd0, 8'h01, 8'h10);
        read_chk("R2 device lo", 3'd0, 8'h02, 8'h08);
        read_chk("R2 device hi", 3'd0, 8'h03, 8'h00);
        read_chk("R2 command", 3'd0, 8'h04, 8'h07);
        read_chk("R2 status", 3'd0, 8'h06, 8'h80);
        read_chk("R2 status hi", 3'd0, 8'h07, 8'h02);
        read_chk("R2 class 0A", 3'd0, 8'h0A, 8'h01);
        read_chk("R2 class 0B", 3'd0, 8'h0B, 8'h06);
        read_chk("R2 header", 3'd0, 8'h0E, 8'h00);
    endtask

    task automatic t_filtered;
        cfg_write(3'd0, 8'h00, 8'hAA);
        read_chk("R4 vendor kept", 3'd0, 8'h00, 8'h39);
        cfg_write(3'd0, 8'h0A, 8'hFF);
        read_chk("R4 class kept", 3'd0, 8'h0A, 8'h01);
        cfg_write(3'd0, 8'h0E, 8'h80);
        read_chk("R4 header kept", 3'd0, 8'h0E, 8'h00);
        cfg_write(3'd0, 8'h30, 8'h55);
        read_chk("R4 locked window", 3'd0, 8'h30, 8'h00);
    endtask

    task automatic t_cmd_status;
        cfg_write(3'd0, 8'h04, 8'hFF);
        read_chk("R5 command all ones", 3'd0, 8'h04, 8'h0F);
        cfg_write(3'd0, 8'h04, 8'h00);
        read_chk("R5 command zero", 3'd0, 8'h04, 8'h07);
        cfg_write(3'd0, 8'h06, 8'hFF);
        read_chk("R5 status cleared", 3'd0, 8'h06, 8'h00);
        cfg_write(3'd0, 8'h05, 8'hFF);
        read_chk("R5 byte 05", 3'd0, 8'h05, 8'h00);
        cfg_write(3'd0, 8'h07, 8'hFF);
        read_chk("R5 byte 07", 3'd0, 8'h07, 8'h02);
    endtask

    task automatic t_order;
        cfg_write(3'd0, 8'h41, 8'h03);
        // R10: outputs already updated at the negedge right after the accepting edge
        check("R10 INTA live", {16'h0, route_irq[3:0], route_en[0]}, {16'h0, 4'h3, 1'b1});
        cfg_write(3'd0, 8'h42, 8'h04);
        cfg_write(3'd0, 8'h43, 8'h09);
        cfg_write(3'd0, 8'h44, 8'h0A);
        check("R3 route_irq order", {16'h0, route_irq}, 32'h0000A493);
        check("R3 route_en", {28'h0, route_en}, 32'hF);
        pin_req = 4'b0100; #1;
        check("R3 INTC alone", {16'h0, irq_req}, 32'h0010);
        pin_req = 4'b0010; #1;
        check("R3 INTB alone", {16'h0, irq_req}, 32'h0200);
        pin_req = 4'b1000; #1;
        check("R8 INTD alone", {16'h0, irq_req}, 32'h0400);
        pin_req = 4'b0000; #1;
        check("R8 idle", {16'h0, irq_req}, 32'h0);
    endtask

    task automatic t_disable;
        cfg_write(3'd0, 8'h43, 8'h89);
        check("R6 INTB disabled", {28'h0, route_en}, 32'hD);
        pin_req = 4'b0010; #1;
        check("R6 no request", {16'h0, irq_req}, 32'h0);
        pin_req = 4'b0000;
        read_chk("R6 readback", 3'd0, 8'h43, 8'h89);
    endtask

    task automatic t_func;
        cfg_write(3'd1, 8'h41, 8'h0F);
        read_chk("R7 slot kept", 3'd0, 8'h41, 8'h03);
        check("R7 route kept", {28'h0, route_irq[3:0]}, 32'h3);
        read_chk("R7 read all ones", 3'd2, 8'h00, 8'hFF);
        read_chk("R7 read all ones route", 3'd7, 8'h41, 8'hFF);
    endtask

    task automatic t_shared;
        cfg_write(3'd0, 8'h41, 8'h05);
        cfg_write(3'd0, 8'h43, 8'h05);
        pin_req = 4'b0001; #1;
        check("R8 shared INTA", {16'h0, irq_req}, 32'h0020);
        pin_req = 4'b0010; #1;
        check("R8 shared INTB", {16'h0, irq_req}, 32'h0020);
        pin_req = 4'b0011; #1;
        check("R8 shared both", {16'h0, irq_req}, 32'h0020);
        pin_req = 4'b0000;
    endtask

    task automatic t_low_irqs;
        cfg_write(3'd0, 8'h41, 8'h00);
        cfg_write(3'd0, 8'h42, 8'h02);
        pin_req = 4'b0101; #1;
        check("R9 irq 0 and 2", {16'h0, irq_req}, 32'h0005);
        pin_req = 4'b0000;
    endtask

    task automatic t_scratch;
        cfg_write(3'd0, 8'h0C, 8'h10);
        cfg_write(3'd0, 8'h0D, 8'h20);
        read_chk("R11 byte 0C", 3'd0, 8'h0C, 8'h10);
        read_chk("R11 byte 0D", 3'd0, 8'h0D, 8'h20);
        cfg_write(3'd0, 8'h50, 8'h77);
        read_chk("R11 above window", 3'd0, 8'h50, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_filtered();
        t_cmd_status();
        t_order();
        t_disable();
        t_func();
        t_shared();
        t_low_irqs();
        t_scratch();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule